// File: doc/BRIEF.md
# Video Memory Host Access Port

This block sits between an 8-bit host processor and a separate 16 KB video memory. The host sees a few byte-wide registers. A control register holds the stride select bit. An address register is filled by two byte writes in a row. A data register reads or writes the video memory at the current video address. Each data access moves the video address forward by 1 or by 32, so a host can fill or read a row or a column of a tile map without reloading the address.

Reads go through a one-deep buffer. A data read returns the byte the buffer held before the access, and the buffer is then refilled from memory at the address just used. The first read after a new address therefore returns stale data. Bytes in the palette region are the exception: they come back directly, and the buffer is still refreshed from the same address. The memory side is a synchronous single-port RAM interface whose read data is valid one cycle after the address is presented.

Top module: `vmem_host_port`

## Requirements
- R1: After reset the video address, control byte, byte toggle and read buffer are all zero, `host_rvalid` is 0 and `mem_we` is 0.
- R2: Register index 6 is the address register. The first write supplies the high part, of which only the low 6 bits are kept. The second write supplies the low byte. The full address takes effect only on the second write.
- R3: A write to register index 7 drives `mem_we`=1, `mem_addr` set to the current video address and `mem_wdata`=`host_wdata` in the strobe cycle, and the byte can be read back later.
- R4: After every read or write of index 7, the video address advances by 1 when bit 2 of the control register (index 0) is 0, and by 32 when that bit is 1.
- R5: A read of index 7 returns the byte held in the read buffer, then loads the buffer from the addressed byte. The result appears on `host_rdata` with `host_rvalid`=1 on the second rising edge after the strobe edge.
- R6: For addresses 0x3F00 to 0x3FFF a read of index 7 returns the addressed byte directly, and it still loads the buffer with that same byte.
- R7: The video address is 14 bits wide and an increment past 0x3FFF wraps to the bottom of the space.
- R8: A high pulse on `clr_toggle` makes the next address-register write be taken as the high part.
- R9: Writes to indices 1 to 5 and reads of any index other than 7 change nothing and raise no `host_rvalid`.
- R10: Data reads on consecutive cycles each return the correct buffered value, with one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_toggle | input | 1 | Resets the address byte toggle |
| host_cs | input | 1 | Host chip select |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 3 | Host register index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_rvalid | output | 1 | Read data valid |
| mem_addr | output | 14 | Video memory address |
| mem_we | output | 1 | Video memory write enable |
| mem_wdata | output | 8 | Video memory write data |
| mem_rdata | input | 8 | Video memory read data, one cycle after the address |

## Verification
The assertions check on every cycle that the address steps by exactly the selected stride on data accesses and holds otherwise. They also check that writes reach the memory port in the strobe cycle, that `host_rvalid` comes exactly two cycles after a data read and never otherwise, and that palette reads return the memory byte directly. Only the bench scenarios can show that the buffered value is the right stale byte, that a palette read refreshes the buffer, that wrap and byte truncation land on the right locations, and that the toggle clear and the ignored indices behave correctly.

// File: rtl/vmp_pkg.sv
package vmp_pkg;
   typedef enum logic [2:0] {
      IDX_CTRL = 3'd0,
      IDX_ADDR = 3'd6,
      IDX_DATA = 3'd7
   } reg_idx_e;

   // control bit that selects the wide stride
   localparam int unsigned STRIDE_BIT = 2;
endpackage

// File: rtl/vmp_addr_unit.sv
module vmp_addr_unit #(
   parameter int unsigned ADDR_W    = 14,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned WIDE_STEP = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_toggle,
   input  logic              addr_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              step_en,
   input  logic              wide_sel,
   output logic [ADDR_W-1:0] vaddr
);
   localparam int unsigned HI_W = ADDR_W - DATA_W;

   generate
      if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_width
         $error("vmp_addr_unit: ADDR_W must lie in DATA_W+1 .. 2*DATA_W");
      end
      if (WIDE_STEP < 1 || WIDE_STEP >= (1 << ADDR_W)) begin : g_bad_step
         $error("vmp_addr_unit: WIDE_STEP out of address range");
      end
   endgenerate

   logic            tog_q;
   logic            tog_eff;
   logic [HI_W-1:0] hi_q;
   logic [ADDR_W-1:0] step;

   // R8: clear wins over the stored toggle state in the same cycle
   assign tog_eff = clr_toggle ? 1'b0 : tog_q;
   assign step    = wide_sel ? ADDR_W'(WIDE_STEP) : ADDR_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tog_q <= 1'b0;
         hi_q  <= '0;
         vaddr <= '0;
      end else begin
         if (clr_toggle) tog_q <= 1'b0;
         if (addr_wr) begin
            if (!tog_eff) begin
               // R2: high part staged, upper bits of the byte dropped
               hi_q  <= wdata[HI_W-1:0];
               tog_q <= 1'b1;
            end else begin
               vaddr <= {hi_q, wdata};
               tog_q <= 1'b0;
            end
         end else if (step_en) begin
            // R4, R7: modular add inside ADDR_W bits
            vaddr <= vaddr + step;
         end
      end
   end
endmodule

// File: rtl/vmp_read_path.sv
module vmp_read_path #(
   parameter int unsigned ADDR_W     = 14,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PAL_TAG_W  = 6,
   parameter logic [PAL_TAG_W-1:0] PAL_TAG = '1,
   parameter bit          PAL_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_go,
   input  logic [ADDR_W-1:0] vaddr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_rvalid
);
   generate
      if (PAL_TAG_W < 1 || PAL_TAG_W > ADDR_W) begin : g_bad_tag
         $error("vmp_read_path: PAL_TAG_W out of range");
      end
   endgenerate

   logic              pend_q;
   logic              pal_q;
   logic [DATA_W-1:0] ret_q;
   logic [DATA_W-1:0] rbuf_q;
   logic [DATA_W-1:0] eff_buf;
   logic              in_pal;
   logic [DATA_W-1:0] result;

   // R10: a fill still in flight is forwarded to a following read
   assign eff_buf = pend_q ? mem_rdata : rbuf_q;
   assign in_pal  = (vaddr[ADDR_W-1 -: PAL_TAG_W] == PAL_TAG);

   generate
      if (PAL_BYPASS) begin : g_bypass
         // R6: palette bytes skip the buffer
         assign result = pal_q ? mem_rdata : ret_q;
      end else begin : g_buffered
         assign result = ret_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pal_q       <= 1'b0;
         ret_q       <= '0;
         rbuf_q      <= '0;
         host_rdata  <= '0;
         host_rvalid <= 1'b0;
      end else begin
         pend_q      <= rd_go;
         host_rvalid <= pend_q;
         if (rd_go) begin
            pal_q <= in_pal;
            ret_q <= eff_buf;
         end
         if (pend_q) begin
            // R5: refill buffer from the byte just fetched
            rbuf_q     <= mem_rdata;
            host_rdata <= result;
         end
      end
   end
endmodule

// File: rtl/vmem_host_port.sv
module vmem_host_port #(
   parameter int unsigned ADDR_W     = 14,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned WIDE_STEP  = 32,
   parameter int unsigned PAL_TAG_W  = 6,
   parameter logic [PAL_TAG_W-1:0] PAL_TAG = 6'h3F,
   parameter bit          PAL_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_toggle,
   input  logic              host_cs,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [2:0]        host_sel,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_rvalid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   import vmp_pkg::*;

   generate
      if (DATA_W <= STRIDE_BIT) begin : g_bad_ctrl
         $error("vmem_host_port: control byte too narrow for stride bit");
      end
   endgenerate

   logic              wr_go;
   logic              rd_go_raw;
   logic              ctrl_wr;
   logic              addr_wr;
   logic              data_wr;
   logic              data_rd;
   logic [DATA_W-1:0] ctrl_q;
   logic              wide_sel;
   logic [ADDR_W-1:0] vaddr;

   // R9: only indices 0, 6 and 7 decode; reads other than 7 fall through
   assign wr_go     = host_cs && host_wr;
   assign rd_go_raw = host_cs && host_rd && !host_wr;
   assign ctrl_wr   = wr_go && (host_sel == IDX_CTRL);
   assign addr_wr   = wr_go && (host_sel == IDX_ADDR);
   assign data_wr   = wr_go && (host_sel == IDX_DATA);
   assign data_rd   = rd_go_raw && (host_sel == IDX_DATA);
   assign wide_sel  = ctrl_q[STRIDE_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= host_wdata;
   end

   vmp_addr_unit #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIDE_STEP(WIDE_STEP)
   ) i_addr (
      .clk(clk), .rst_n(rst_n), .clr_toggle(clr_toggle),
      .addr_wr(addr_wr), .wdata(host_wdata),
      .step_en(data_wr || data_rd), .wide_sel(wide_sel),
      .vaddr(vaddr)
   );

   vmp_read_path #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAL_TAG_W(PAL_TAG_W),
      .PAL_TAG(PAL_TAG), .PAL_BYPASS(PAL_BYPASS)
   ) i_rd (
      .clk(clk), .rst_n(rst_n), .rd_go(data_rd), .vaddr(vaddr),
      .mem_rdata(mem_rdata), .host_rdata(host_rdata),
      .host_rvalid(host_rvalid)
   );

   // R3: memory port follows the current video address
   assign mem_addr  = vaddr;
   assign mem_we    = data_wr;
   assign mem_wdata = host_wdata;
endmodule

// File: rtl/vmp_checker.sv
module vmp_checker #(
   parameter int unsigned ADDR_W     = 14,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned WIDE_STEP  = 32,
   parameter int unsigned PAL_TAG_W  = 6,
   parameter logic [PAL_TAG_W-1:0] PAL_TAG = 6'h3F,
   parameter bit          PAL_BYPASS = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_cs,
   input logic              host_rd,
   input logic              host_wr,
   input logic [2:0]        host_sel,
   input logic [DATA_W-1:0] host_wdata,
   input logic [DATA_W-1:0] host_rdata,
   input logic              host_rvalid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_we,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              wide_sel
);
   logic d_wr, d_rd, a_wr, pal_now;
   assign d_wr    = host_cs && host_wr && host_sel == 3'd7;
   assign d_rd    = host_cs && host_rd && !host_wr && host_sel == 3'd7;
   assign a_wr    = host_cs && host_wr && host_sel == 3'd6;
   assign pal_now = mem_addr[ADDR_W-1 -: PAL_TAG_W] == PAL_TAG;

   p_write_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
      d_wr |-> (mem_we && mem_wdata == host_wdata));

   p_no_stray_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !d_wr |-> !mem_we);

   p_stride_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (d_wr || d_rd) |=> mem_addr == ADDR_W'($past(mem_addr) +
         ($past(wide_sel) ? ADDR_W'(WIDE_STEP) : ADDR_W'(1))));

   p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(d_wr || d_rd || a_wr) |=> $stable(mem_addr));

   p_rvalid_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      d_rd |-> ##2 host_rvalid);

   p_rvalid_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid |-> $past(d_rd, 2));

   p_palette_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (PAL_BYPASS && host_rvalid && $past(pal_now, 2)) |->
         host_rdata == $past(mem_rdata));
endmodule

bind vmem_host_port vmp_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIDE_STEP(WIDE_STEP),
   .PAL_TAG_W(PAL_TAG_W), .PAL_TAG(PAL_TAG), .PAL_BYPASS(PAL_BYPASS)
) i_vmp_checker (
   .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_rd(host_rd),
   .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
   .host_rdata(host_rdata), .host_rvalid(host_rvalid),
   .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
   .mem_rdata(mem_rdata), .wide_sel(wide_sel)
);

// File: tb/test_vmem_host_port.sv
module test_vmem_host_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr_toggle = 1'b0;
   logic       host_cs = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
   logic [2:0] host_sel = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       host_rvalid;
   logic [13:0] mem_addr;
   logic       mem_we;
   logic [7:0] mem_wdata;
   logic [7:0] mem_rdata = '0;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   vmem_host_port i_vmem_host_port (
      .clk(clk), .rst_n(rst_n), .clr_toggle(clr_toggle),
      .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
      .host_sel(host_sel), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_rvalid(host_rvalid),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   // memory model: background pattern plus a log of written bytes
   logic [13:0] log_a [64];
   logic [7:0]  log_d [64];
   int          log_n = 0;

   function automatic logic [7:0] lookup(input logic [13:0] a);
      logic [7:0] v = a[7:0] ^ 8'hA5;
      for (int i = 0; i < 64; i++)
         if (i < log_n && log_a[i] == a) v = log_d[i];
      return v;
   endfunction

   always @(posedge clk) begin
      mem_rdata <= lookup(mem_addr);
      if (mem_we && log_n < 64) begin
         log_a[log_n] = mem_addr;
         log_d[log_n] = mem_wdata;
         log_n = log_n + 1;
      end
   end

   task automatic chk(input string req, input logic [15:0] act,
                      input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] sel, input logic [7:0] d,
                         input bit chk_addr, input logic [15:0] exp,
                         input string req);
      @(negedge clk);
      host_cs = 1'b1; host_wr = 1'b1; host_sel = sel; host_wdata = d;
      #1;
      if (chk_addr) begin
         chk(req, {2'b00, mem_addr}, exp);
         chk(req, {15'd0, mem_we}, 16'd1);
      end
      @(negedge clk);
      host_cs = 1'b0; host_wr = 1'b0;
   endtask

   task automatic reg_rd(input logic [2:0] sel, output logic [7:0] d,
                         output logic v);
      @(negedge clk);
      host_cs = 1'b1; host_rd = 1'b1; host_sel = sel;
      @(negedge clk);
      host_cs = 1'b0; host_rd = 1'b0;
      @(negedge clk);
      d = host_rdata; v = host_rvalid;
   endtask

   typedef struct packed {
      logic [1:0]  op;    // 0 register write, 1 data write with address check, 2 data read
      logic [2:0]  sel;
      logic [7:0]  data;
      logic [15:0] exp;
   } vec_t;

   localparam int NV = 31;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 3'd6, 8'h21, 16'h0000},   // R2 high part
      '{2'd0, 3'd6, 8'h08, 16'h0000},   // R2 low byte -> 0x2108
      '{2'd2, 3'd7, 8'h00, 16'h0000},   // R5 stale reset buffer (R1)
      '{2'd2, 3'd7, 8'h00, 16'h00AD},   // R5 byte at 0x2108
      '{2'd0, 3'd0, 8'h04, 16'h0000},   // R4 wide stride on
      '{2'd2, 3'd7, 8'h00, 16'h00AC},   // R4 read at 0x210A
      '{2'd2, 3'd7, 8'h00, 16'h00AF},   // R4 read at 0x212A
      '{2'd1, 3'd7, 8'h77, 16'h214A},   // R3 write lands at 0x214A
      '{2'd0, 3'd6, 8'h21, 16'h0000},   // R2
      '{2'd0, 3'd6, 8'h4A, 16'h0000},   // R2 -> 0x214A
      '{2'd2, 3'd7, 8'h00, 16'h008F},   // R5 stale byte from 0x212A
      '{2'd2, 3'd7, 8'h00, 16'h0077},   // R3 written byte read back
      '{2'd0, 3'd0, 8'h00, 16'h0000},   // R4 stride 1
      '{2'd0, 3'd6, 8'h3F, 16'h0000},   // R6
      '{2'd0, 3'd6, 8'h10, 16'h0000},   // R6 -> 0x3F10
      '{2'd2, 3'd7, 8'h00, 16'h00B5},   // R6 direct palette byte
      '{2'd0, 3'd6, 8'h20, 16'h0000},   // R6
      '{2'd0, 3'd6, 8'h00, 16'h0000},   // R6 -> 0x2000
      '{2'd2, 3'd7, 8'h00, 16'h00B5},   // R6 buffer refreshed by palette read
      '{2'd0, 3'd6, 8'h7F, 16'h0000},   // R2 upper bits dropped
      '{2'd0, 3'd6, 8'hFF, 16'h0000},   // R2 -> 0x3FFF
      '{2'd1, 3'd7, 8'h11, 16'h3FFF},   // R7
      '{2'd1, 3'd7, 8'h22, 16'h0000},   // R7 wrap by 1
      '{2'd0, 3'd3, 8'h55, 16'h0000},   // R9 ignored index
      '{2'd0, 3'd1, 8'h04, 16'h0000},   // R9 ignored index
      '{2'd1, 3'd7, 8'h33, 16'h0001},   // R9 address and stride untouched
      '{2'd0, 3'd0, 8'h04, 16'h0000},   // R4
      '{2'd0, 3'd6, 8'h3F, 16'h0000},   // R7
      '{2'd0, 3'd6, 8'hF0, 16'h0000},   // R7 -> 0x3FF0
      '{2'd1, 3'd7, 8'h44, 16'h3FF0},   // R4
      '{2'd1, 3'd7, 8'h55, 16'h0010}    // R7 wrap by 32
   };

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures",
                  checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      logic v;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 rvalid", {15'd0, host_rvalid}, 16'd0);
      chk("R1 we", {15'd0, mem_we}, 16'd0);
      chk("R1 addr", {2'b00, mem_addr}, 16'h0000);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         vec_t t = VECS[i];
         if (t.op == 2'd2) begin
            reg_rd(t.sel, d, v);
            chk($sformatf("vec%0d valid", i), {15'd0, v}, 16'd1);
            chk($sformatf("vec%0d rdata", i), {8'd0, d}, t.exp);
         end else begin
            reg_wr(t.sel, t.data, t.op == 2'd1, t.exp,
                   $sformatf("vec%0d addr", i));
         end
      end

      // R9 non-data read raises nothing
      reg_rd(3'd0, d, v);
      chk("R9 read idx0 valid", {15'd0, v}, 16'd0);
      @(negedge clk);
      chk("R9 read idx0 late", {15'd0, host_rvalid}, 16'd0);

      // R8 toggle clear
      reg_wr(3'd6, 8'h12, 1'b0, 16'h0, "R8");
      @(negedge clk); clr_toggle = 1'b1;
      @(negedge clk); clr_toggle = 1'b0;
      reg_wr(3'd6, 8'h05, 1'b0, 16'h0, "R8");
      reg_wr(3'd6, 8'h06, 1'b0, 16'h0, "R8");
      reg_wr(3'd7, 8'h99, 1'b1, 16'h0506, "R8 addr after clear");

      // R10 back-to-back reads
      reg_wr(3'd0, 8'h00, 1'b0, 16'h0, "R10");
      reg_wr(3'd6, 8'h21, 1'b0, 16'h0, "R10");
      reg_wr(3'd6, 8'h08, 1'b0, 16'h0, "R10");
      @(negedge clk);
      host_cs = 1'b1; host_rd = 1'b1; host_sel = 3'd7;
      @(negedge clk);
      @(negedge clk);
      chk("R10 first valid", {15'd0, host_rvalid}, 16'd1);
      @(negedge clk);
      host_cs = 1'b0; host_rd = 1'b0;
      chk("R10 second", {7'd0, host_rvalid, host_rdata}, 16'h01AD);
      @(negedge clk);
      chk("R10 third", {7'd0, host_rvalid, host_rdata}, 16'h01AC);

      // R1 reset mid-run clears buffer and address
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 addr after reset", {2'b00, mem_addr}, 16'h0000);
      rst_n = 1'b1;
      reg_rd(3'd7, d, v);
      chk("R1 buffer after reset", {7'd0, v, d}, 16'h0100);

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule